// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt lines, grouped in banks of 32. Each line can also be raised by software. Each line has a mask bit, a 6-bit priority and a steering bit, which sends the line to either a normal request output or a fast request output. For each output the controller picks the pending line with the best priority. It latches that line's number and priority so that software can read them, and it drives the output until software writes an acknowledge for that output.

Software reaches every register through a single-cycle 32-bit word-addressed port. Read data is combinational from the address. A write takes effect at the clock edge where `req_valid` and `req_write` are both high. A common priority threshold filters both outputs. Setting the threshold to 0xFF turns the filter off.

Top module: `prio_intc`

## Requirements
- R1: Reset leaves the block in this state:
  - every mask bit is 1;
  - every level register is 0;
  - every software bit is 0;
  - the threshold is 0xFF;
  - both outputs are low;
  - both active-number registers read 0x80 (spurious bit set).
- R2: Writing to the mask registers:
  - a 1 written to mask-clear (bank word +2) clears that mask bit, which enables the line;
  - a 1 written to mask-set (bank word +3) sets that mask bit;
  - 0 bits leave the mask unchanged;
  - reading bank word +1 returns the mask;
  - a masked line never raises an output.
- R3: Writing to the software registers:
  - a 1 written to software-set (bank word +4) raises that line's software bit;
  - a 1 written to software-clear (bank word +5) drops it;
  - reading bank word +4 returns the software bits;
  - a software bit counts as pending exactly like a high input.
- R4: The status words of each bank:
  - bank word +0 reads the raw input lines;
  - bank word +6 reads (input OR software) AND NOT mask for lines steered to the normal output;
  - bank word +7 reads the same for lines steered to the fast output;
  - the threshold does not affect these words.
- R5: The level register of line n sits at word 64+n. Bit 0 steers the line (0 = normal, 1 = fast). Bits 7:2 hold the priority. Bit 1 reads 0.
- R6: A candidate is a pending, unmasked line that is steered to the output and passes the threshold. Among the candidates, the lowest priority value wins. Ties go to the lowest line number.
- R7: How an output holds its choice:
  - the choice is latched one edge after the candidate appears;
  - the output then rises, and the active number (word 0 normal, word 1 fast, bits 6:0) and priority (word 2 normal, word 3 fast, bits 5:0) stay frozen;
  - writing word 4 with bit 0 (normal) or bit 1 (fast) set drops that output at the next edge;
  - a new choice is made at the edge after that.
- R8: The threshold sits at word 5. When it is not 0xFF, a line is a candidate only if its priority is below it, so 0x00 blocks every line.
- R9: An idle output that finds no candidate keeps its output low. Its active number and priority words then read with bit 7 set and the low bits at 0.
- R10: Writes to words 0–3 and to bank words +0, +6 and +7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_LINES | Level-sensitive interrupt lines |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data for req_addr |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with 128 lines, which is four banks. This brings the top bank and line 127 within reach, so the full 7-bit active number and the last level word at address 191 are both exercised. The 96-line default differs only in the bank count. The bench drives ties between software-raised lines in one bank and fast-steered lines in the top bank, and it sets the threshold so that it either blocks every candidate or admits exactly one.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_LINES = 96,
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          req_rdata,
  output logic                 irq_out,
  output logic                 fiq_out
);
  localparam int NB     = NUM_LINES / 32;
  localparam int A_CTRL = 4;
  localparam int A_THR  = 5;
  localparam int A_BANK = 16;
  localparam int A_LVL  = 64;

  logic [NUM_LINES-1:0] mask, sw, to_fiq, act, pend_irq, pend_fiq;
  logic [5:0] prio [NUM_LINES];
  logic [7:0] thr;
  logic [1:0] busy, spur, found, ack;
  logic [6:0] num [2];
  logic [5:0] pri [2];
  logic [6:0] bnum [2];
  logic [5:0] bpri [2];
  logic wr;
  int ra;

  assign ra       = int'(req_addr);
  assign wr       = req_valid && req_write;
  assign act      = (line_in | sw) & ~mask;
  assign pend_irq = act & ~to_fiq;
  assign pend_fiq = act & to_fiq;
  assign ack[0]   = wr && ra == A_CTRL && req_wdata[0];
  assign ack[1]   = wr && ra == A_CTRL && req_wdata[1];
  assign irq_out  = busy[0];
  assign fiq_out  = busy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '1;
      sw     <= '0;
      to_fiq <= '0;
      thr    <= 8'hFF;
      for (int i = 0; i < NUM_LINES; i++) prio[i] <= '0;
    end else if (wr) begin
      if (ra == A_THR) thr <= req_wdata[7:0];
      for (int b = 0; b < NB; b++) begin
        if (ra == A_BANK + 8*b + 2) mask[b*32 +: 32] <= mask[b*32 +: 32] & ~req_wdata;
        if (ra == A_BANK + 8*b + 3) mask[b*32 +: 32] <= mask[b*32 +: 32] | req_wdata;
        if (ra == A_BANK + 8*b + 4) sw[b*32 +: 32]   <= sw[b*32 +: 32] | req_wdata;
        if (ra == A_BANK + 8*b + 5) sw[b*32 +: 32]   <= sw[b*32 +: 32] & ~req_wdata;
      end
      for (int i = 0; i < NUM_LINES; i++) begin
        if (ra == A_LVL + i) begin
          prio[i]   <= req_wdata[7:2];
          to_fiq[i] <= req_wdata[0];
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      found[o] = 1'b0;
      bnum[o]  = '0;
      bpri[o]  = '1;
      for (int i = 0; i < NUM_LINES; i++) begin
        if ((o == 0 ? pend_irq[i] : pend_fiq[i]) &&
            (thr == 8'hFF || {2'b00, prio[i]} < thr) &&
            (!found[o] || prio[i] < bpri[o])) begin
          found[o] = 1'b1;
          bnum[o]  = 7'(i);
          bpri[o]  = prio[i];
        end
      end
    end
  end

  for (genvar o = 0; o < 2; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[o] <= 1'b0;
        spur[o] <= 1'b1;
        num[o]  <= '0;
        pri[o]  <= '0;
      end else if (busy[o]) begin
        if (ack[o]) busy[o] <= 1'b0;
      end else if (found[o]) begin
        busy[o] <= 1'b1;
        spur[o] <= 1'b0;
        num[o]  <= bnum[o];
        pri[o]  <= bpri[o];
      end else begin
        spur[o] <= 1'b1;
        num[o]  <= '0;
        pri[o]  <= '0;
      end
    end
  end

  always_comb begin
    req_rdata = '0;
    case (ra)
      0: req_rdata = {24'b0, spur[0], num[0]};
      1: req_rdata = {24'b0, spur[1], num[1]};
      2: req_rdata = {24'b0, spur[0], 1'b0, pri[0]};
      3: req_rdata = {24'b0, spur[1], 1'b0, pri[1]};
      A_THR: req_rdata = {24'b0, thr};
      default: ;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (ra == A_BANK + 8*b + 0) req_rdata = line_in[b*32 +: 32];
      if (ra == A_BANK + 8*b + 1) req_rdata = mask[b*32 +: 32];
      if (ra == A_BANK + 8*b + 4) req_rdata = sw[b*32 +: 32];
      if (ra == A_BANK + 8*b + 6) req_rdata = pend_irq[b*32 +: 32];
      if (ra == A_BANK + 8*b + 7) req_rdata = pend_fiq[b*32 +: 32];
    end
    for (int i = 0; i < NUM_LINES; i++)
      if (ra == A_LVL + i) req_rdata = {24'b0, prio[i], 1'b0, to_fiq[i]};
  end
endmodule

module prio_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_irq,
  input logic       ack_fiq,
  input logic       irq_out,
  input logic       fiq_out,
  input logic [6:0] irq_num,
  input logic [6:0] fiq_num,
  input logic       irq_spur,
  input logic       fiq_spur,
  input logic [7:0] thr
);
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !ack_irq |=> irq_out && $stable(irq_num)); // R7
  AST_FIQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out && !ack_fiq |=> fiq_out && $stable(fiq_num)); // R7
  AST_IRQ_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && ack_irq |=> !irq_out); // R7
  AST_FIQ_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out && ack_fiq |=> !fiq_out); // R7
  AST_IRQ_NOT_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !irq_spur); // R9
  AST_FIQ_NOT_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> !fiq_spur); // R9
  AST_THR_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(thr) != 8'h00); // R8
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_irq(ack[0]), .ack_fiq(ack[1]),
  .irq_out(irq_out), .fiq_out(fiq_out), .irq_num(num[0]), .fiq_num(num[1]),
  .irq_spur(spur[0]), .fiq_spur(spur[1]), .thr(thr)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int N = 128;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] line_in = '0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rdata;
  logic irq_out, fiq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  prio_intc #(.NUM_LINES(N), .AW(8)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  always #2.5 clk = ~clk;

  bit mmask[N], msw[N], mfiq[N];
  int mpri[N], mthr;
  bit mbusy[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mmask[i] = 1; msw[i] = 0; mfiq[i] = 0; mpri[i] = 0; end
      mthr = 255; mbusy[0] = 0; mbusy[1] = 0;
    end else begin
      int a;
      a = req_addr;
      for (int o = 0; o < 2; o++) begin
        if (mbusy[o]) begin
          if (req_valid && req_write && a == 4 && req_wdata[o]) mbusy[o] = 0;
        end else begin
          int best;
          best = -1;
          for (int i = 0; i < N; i++)
            if ((line_in[i] || msw[i]) && !mmask[i] && int'(mfiq[i]) == o &&
                (mthr == 255 || mpri[i] < mthr) && (best < 0 || mpri[i] < mpri[best]))
              best = i;
          if (best >= 0) mbusy[o] = 1;
        end
      end
      if (req_valid && req_write) begin
        if (a == 5) mthr = int'(req_wdata[7:0]);
        for (int b = 0; b < N/32; b++)
          for (int j = 0; j < 32; j++) begin
            if (a == 16 + 8*b + 2 && req_wdata[j]) mmask[b*32+j] = 0;
            if (a == 16 + 8*b + 3 && req_wdata[j]) mmask[b*32+j] = 1;
            if (a == 16 + 8*b + 4 && req_wdata[j]) msw[b*32+j] = 1;
            if (a == 16 + 8*b + 5 && req_wdata[j]) msw[b*32+j] = 0;
          end
        if (a >= 64 && a < 64 + N) begin
          mpri[a-64] = int'(req_wdata[7:2]);
          mfiq[a-64] = req_wdata[0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_out !== mbusy[0] || fiq_out !== mbusy[1]) begin
        fails++;
        $display("FAIL R7 outputs irq/fiq=%b%b expected %b%b", irq_out, fiq_out, mbusy[0], mbusy[1]);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'(a);
    #1;
    checks++;
    if (req_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d got %h expected %h", tag, a, req_rdata, exp);
    end
    req_valid = 0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 32'h80, "R1 active irq");
    rd(1, 32'h80, "R1 active fiq");
    rd(5, 32'hFF, "R1 threshold");
    rd(17, 32'hFFFFFFFF, "R1 mask bank0");
    rd(64+5, 32'h0, "R1 level 5");
    chk_bit(irq_out, 1'b0, "R1 irq_out");

    @(negedge clk); line_in[5] = 1'b1;
    rd(16, 32'h20, "R4 raw bank0");
    rd(22, 32'h0, "R4 pending masked");
    chk_bit(irq_out, 1'b0, "R2 masked line");

    wr(18, 32'h20);
    rd(17, 32'hFFFFFFDF, "R2 mask clear");
    rd(0, 32'd5, "R6 active line 5");
    rd(2, 32'd0, "R7 active prio");
    rd(22, 32'h20, "R4 pending irq");
    chk_bit(irq_out, 1'b1, "R7 irq raised");
    wr(19, 32'h0);
    rd(17, 32'hFFFFFFDF, "R2 zero write no effect");

    wr(64+5, 32'h28);
    rd(64+5, 32'h28, "R5 level readback");
    rd(2, 32'd0, "R7 prio frozen");

    wr(28, 32'h300);
    wr(64+40, 32'hC);
    wr(64+41, 32'hC);
    wr(26, 32'h300);
    rd(28, 32'h300, "R3 sw readback");
    rd(0, 32'd5, "R7 held until ack");
    wr(4, 32'h1);
    rd(0, 32'd40, "R6 tie lowest number");
    rd(2, 32'd3, "R6 active prio");

    wr(29, 32'h100);
    rd(28, 32'h200, "R3 sw clear");
    rd(0, 32'd40, "R7 held after source cleared");
    wr(4, 32'h1);
    rd(0, 32'd41, "R3 sw-only line chosen");

    wr(64+127, 32'h9);
    wr(44, 32'h80000000);
    wr(42, 32'h80000000);
    rd(64+127, 32'h9, "R5 steer fast");
    rd(1, 32'd127, "R5 fast active");
    rd(3, 32'd2, "R5 fast prio");
    rd(47, 32'h80000000, "R4 pending fiq");
    rd(46, 32'h0, "R4 pending irq bank3");
    chk_bit(fiq_out, 1'b1, "R5 fiq_out");
    rd(0, 32'd41, "R7 irq unaffected by fiq");

    wr(5, 32'd3);
    wr(4, 32'h1);
    rd(0, 32'h80, "R9 spurious under threshold");
    chk_bit(irq_out, 1'b0, "R8 threshold blocks");
    wr(5, 32'd4);
    rd(0, 32'd41, "R8 threshold admits prio 3");

    wr(5, 32'd0);
    wr(4, 32'h3);
    rd(0, 32'h80, "R8 zero threshold irq");
    rd(1, 32'h80, "R8 zero threshold fiq");
    rd(3, 32'h80, "R9 fiq prio spurious");
    rd(22, 32'h20, "R4 pending ignores threshold");

    wr(0, 32'h12);
    wr(16, 32'h0);
    wr(22, 32'hFFFFFFFF);
    wr(47, 32'h0);
    rd(0, 32'h80, "R10 active write ignored");
    rd(16, 32'h20, "R10 raw write ignored");
    rd(22, 32'h20, "R10 pending irq write ignored");
    rd(47, 32'h80000000, "R10 pending fiq write ignored");

    wr(5, 32'hFF);
    rd(0, 32'd41, "R6 best priority wins");
    rd(1, 32'd127, "R6 fast chosen again");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule